// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache with Run-Time Write Policies

This block sits between a single processor load/store port and a plain word-wide main-memory port. It holds 512 bytes by default, arranged as sixteen sets of two ways, with four 32-bit words per line. Both ports use word addresses; the default 14-bit word address covers a 16-bit byte space. Each lookup compares the tags of both ways of the addressed set in the same cycle. On a miss that needs a slot, an empty way is used first. If both ways are full, the way that was touched least recently is replaced.

Two level inputs choose how writes behave. `cfg_write_back` selects what a write hit does: it either updates only the line and marks it dirty, or it updates the line and also sends the word to memory. `cfg_write_alloc` selects what a write miss does: it either brings the line in and then finishes as a hit, or it sends the word straight to memory and leaves the cache alone. All four combinations come from the same controller. The inputs are read when a request is looked up, so they may change between requests.

Line transfers to and from memory are four single-word beats. Each beat is a request that is held until `mem_ready` is sampled high at a clock edge. A dirty victim is written out in full before the reads for the new line start.

Top module: `set_assoc_cache`

## Requirements
- R1: A word address splits into word-in-line bits [1:0], set bits [5:2] and tag bits [13:6]. A read returns the word that the word-in-line bits select.
- R2: A hit requires a valid way in the addressed set whose stored tag equals the address tag. The same tag held in another set does not count, and the request goes to memory as a miss.
- R3: A read hit raises `cpu_done` for one cycle, one cycle after the request is accepted, with the stored word on `cpu_rdata`. It causes no memory traffic.
- R4: A read miss reads the four words of the line from memory in ascending order, starting at the line base. It then returns the requested word, and the line stays resident for later hits.
- R5: When both ways of a set are valid, a fill replaces the way that was used less recently. Read hits, write hits and fills all count as use.
- R6: With write-through selected, a write hit updates the line and issues exactly one memory word write. `cpu_done` follows the cycle in which memory accepts that write.
- R7: With write-back selected, a write hit causes no memory traffic and marks the line dirty. When a dirty line is evicted, its four words are written to memory before any read for the new line.
- R8: With write-allocate selected, a write miss first fills the line and then completes as a write hit under the current hit policy.
- R9: With no-write-allocate selected, a write miss issues one memory word write. It changes neither the line contents, nor the valid state, nor the replacement order.
- R10: `cpu_ready` is high only while the block is idle, and no memory request is raised then. A raised memory request keeps its address, direction and data until `mem_ready` is seen.
- R11: After reset, `cpu_ready` is high, no memory request is active and every way is empty, so the first access to any line misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_write_back | input | 1 | 1: write hits stay in the cache as dirty; 0: write hits also write memory |
| cfg_write_alloc | input | 1 | 1: write misses fill the line; 0: write misses go only to memory |
| cpu_req | input | 1 | Processor request, accepted when `cpu_ready` is high |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 14 | Word address of the access |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Block idle and able to accept a request |
| cpu_done | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 32 | Read data, valid with `cpu_done` on reads |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 for memory write beat |
| mem_addr | output | 14 | Word address of the beat |
| mem_wdata | output | 32 | Write beat data |
| mem_ready | input | 1 | Memory accepts or answers the beat in this cycle |
| mem_rdata | input | 32 | Read beat data, valid with `mem_ready` |

## Verification
The bench targets conflict pairs in one set where only the recency order decides the victim. A design with inverted or missing replacement updates evicts the line that was just used, and the predicted beat list then shows the wrong tag. It makes a line dirty, then evicts it. A controller that skips or reorders the write-back either loses the written word on the next read or shows reads before writes. It also issues no-allocate write misses between accesses. A design that allocates anyway, or moves the replacement order, changes the next miss's victim and produces extra fill traffic.

// File: rtl/cache_pkg.sv
package cache_pkg;
  // The replacement state is one bit per set, which fixes the way count.
  localparam int WAYS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL,
    ST_WORD
  } cache_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int WAYS  = 2,
  parameter int SETS  = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 8,
  parameter int WAY_W = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            set_idx,
  input  logic [TAG_W-1:0]            cmp_tag,
  output logic [WAYS-1:0]             way_hit,
  output logic [WAYS-1:0]             way_valid,
  output logic [WAYS-1:0]             way_dirty,
  output logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  output logic [WAY_W-1:0]            lru_way,
  input  logic                        fill_en,
  input  logic [WAY_W-1:0]            fill_way,
  input  logic                        dirty_en,
  input  logic [WAY_W-1:0]            dirty_way,
  input  logic                        touch_en,
  input  logic [WAY_W-1:0]            touch_way
);
  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             fill_me;
    logic             dirty_me;

    assign fill_me  = fill_en && (fill_way == WAY_W'(w));
    assign dirty_me = dirty_en && (dirty_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else begin
        if (fill_me) begin
          valid_q[set_idx] <= 1'b1;
          dirty_q[set_idx] <= 1'b0;
        end else if (dirty_me) begin
          dirty_q[set_idx] <= 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (fill_me) tag_q[set_idx] <= cmp_tag;
    end

    assign way_valid[w] = valid_q[set_idx];
    assign way_dirty[w] = dirty_q[set_idx];
    assign way_tag[w]   = tag_q[set_idx];
    assign way_hit[w]   = valid_q[set_idx] && (tag_q[set_idx] == cmp_tag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else if (touch_en) begin
      lru_q[set_idx] <= ~touch_way;
    end
  end

  assign lru_way = lru_q[set_idx];
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int WAYS   = 2,
  parameter int SETS   = 16,
  parameter int WPL    = 4,
  parameter int IDX_W  = 4,
  parameter int WSEL_W = 2,
  parameter int DATA_W = 32,
  parameter int WAY_W  = 1
) (
  input  logic                        clk,
  input  logic [IDX_W-1:0]            set_idx,
  input  logic [WSEL_W-1:0]           rd_word,
  input  logic                        wr_en,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [WSEL_W-1:0]           wr_word,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [WAYS-1:0][DATA_W-1:0] rd_data
);
  localparam int DEPTH = SETS * WPL;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DATA_W-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == WAY_W'(w))) word_q[{set_idx, wr_word}] <= wr_data;
    end

    assign rd_data[w] = word_q[{set_idx, rd_word}];
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int WADDR_W = 14,
  parameter int DATA_W  = 32,
  parameter int WAYS    = 2,
  parameter int IDX_W   = 4,
  parameter int WSEL_W  = 2,
  parameter int TAG_W   = 8,
  parameter int WAY_W   = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_write_back,
  input  logic                        cfg_write_alloc,
  input  logic                        cpu_req,
  input  logic                        cpu_we,
  input  logic [WADDR_W-1:0]          cpu_addr,
  input  logic [DATA_W-1:0]           cpu_wdata,
  output logic                        cpu_ready,
  output logic                        cpu_done,
  output logic [DATA_W-1:0]           cpu_rdata,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [WADDR_W-1:0]          mem_addr,
  output logic [DATA_W-1:0]           mem_wdata,
  input  logic                        mem_ready,
  input  logic [DATA_W-1:0]           mem_rdata,
  output logic [IDX_W-1:0]            set_idx,
  output logic [TAG_W-1:0]            req_tag,
  input  logic [WAYS-1:0]             way_hit,
  input  logic [WAYS-1:0]             way_valid,
  input  logic [WAYS-1:0]             way_dirty,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [WAY_W-1:0]            lru_way,
  input  logic [WAYS-1:0][DATA_W-1:0] way_data,
  output logic                        tag_fill,
  output logic [WAY_W-1:0]            tag_fill_way,
  output logic                        tag_dirty,
  output logic [WAY_W-1:0]            tag_dirty_way,
  output logic                        lru_touch,
  output logic [WAY_W-1:0]            lru_touch_way,
  output logic                        dat_we,
  output logic [WAY_W-1:0]            dat_way,
  output logic [WSEL_W-1:0]           dat_word,
  output logic [DATA_W-1:0]           dat_wdata,
  output logic [WSEL_W-1:0]           dat_rd_word
);
  localparam logic [WSEL_W-1:0] LAST_BEAT = '1;

  cache_state_e        state_q, state_d;
  logic [WSEL_W-1:0]   beat_q, beat_d;
  logic [WAY_W-1:0]    victim_q, victim_d;
  logic                req_we_q;
  logic [WADDR_W-1:0]  req_addr_q;
  logic [DATA_W-1:0]   req_wdata_q;
  logic                cap_en;
  logic [WAY_W-1:0]    hit_way;
  logic [WAY_W-1:0]    victim_sel;
  logic                hit_any;
  logic [WSEL_W-1:0]   req_word;

  assign req_tag  = req_addr_q[WADDR_W-1 -: TAG_W];
  assign set_idx  = req_addr_q[WSEL_W +: IDX_W];
  assign req_word = req_addr_q[WSEL_W-1:0];
  assign hit_any  = |way_hit;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_way = WAY_W'(w);
    end
  end

  // First empty way wins; with a full set the recency bit names the victim.
  always_comb begin
    victim_sel = lru_way;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) victim_sel = WAY_W'(w);
    end
  end

  assign cpu_ready     = (state_q == ST_IDLE);
  assign cpu_rdata     = way_data[hit_way];
  assign tag_fill_way  = victim_q;
  assign tag_dirty_way = hit_way;

  always_comb begin
    state_d       = state_q;
    beat_d        = beat_q;
    victim_d      = victim_q;
    cap_en        = 1'b0;
    cpu_done      = 1'b0;
    mem_req       = 1'b0;
    mem_we        = 1'b0;
    mem_addr      = '0;
    mem_wdata     = '0;
    tag_fill      = 1'b0;
    tag_dirty     = 1'b0;
    lru_touch     = 1'b0;
    lru_touch_way = hit_way;
    dat_we        = 1'b0;
    dat_way       = hit_way;
    dat_word      = req_word;
    dat_wdata     = req_wdata_q;
    dat_rd_word   = req_word;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          cap_en  = 1'b1;
          state_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit_any) begin
          lru_touch = 1'b1;
          if (!req_we_q) begin
            cpu_done = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            dat_we = 1'b1;
            if (cfg_write_back) begin
              tag_dirty = 1'b1;
              cpu_done  = 1'b1;
              state_d   = ST_IDLE;
            end else begin
              state_d = ST_WORD;
            end
          end
        end else if (req_we_q && !cfg_write_alloc) begin
          state_d = ST_WORD;
        end else begin
          victim_d = victim_sel;
          beat_d   = '0;
          state_d  = (way_valid[victim_sel] && way_dirty[victim_sel]) ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT: begin
        mem_req     = 1'b1;
        mem_we      = 1'b1;
        mem_addr    = {way_tag[victim_q], set_idx, beat_q};
        dat_rd_word = beat_q;
        mem_wdata   = way_data[victim_q];
        if (mem_ready) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {req_tag, set_idx, beat_q};
        if (mem_ready) begin
          dat_we    = 1'b1;
          dat_way   = victim_q;
          dat_word  = beat_q;
          dat_wdata = mem_rdata;
          beat_d    = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) begin
            tag_fill      = 1'b1;
            lru_touch     = 1'b1;
            lru_touch_way = victim_q;
            state_d       = ST_LOOKUP;
          end
        end
      end
      ST_WORD: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = req_addr_q;
        mem_wdata = req_wdata_q;
        if (mem_ready) begin
          cpu_done = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      beat_q   <= '0;
      victim_q <= '0;
    end else begin
      state_q  <= state_d;
      beat_q   <= beat_d;
      victim_q <= victim_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      req_we_q    <= cpu_we;
      req_addr_q  <= cpu_addr;
      req_wdata_q <= cpu_wdata;
    end
  end
endmodule

// File: rtl/set_assoc_cache.sv
module set_assoc_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int CACHE_BYTES = 512,
  parameter int LINE_BYTES  = 16
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      cfg_write_back,
  input  logic                                      cfg_write_alloc,
  input  logic                                      cpu_req,
  input  logic                                      cpu_we,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]        cpu_addr,
  input  logic [DATA_W-1:0]                         cpu_wdata,
  output logic                                      cpu_ready,
  output logic                                      cpu_done,
  output logic [DATA_W-1:0]                         cpu_rdata,
  output logic                                      mem_req,
  output logic                                      mem_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]        mem_addr,
  output logic [DATA_W-1:0]                         mem_wdata,
  input  logic                                      mem_ready,
  input  logic [DATA_W-1:0]                         mem_rdata
);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int WADDR_W = ADDR_W - BYTE_W;
  localparam int WPL     = LINE_BYTES / (DATA_W / 8);
  localparam int WSEL_W  = $clog2(WPL);
  localparam int SETS    = CACHE_BYTES / (LINE_BYTES * WAYS);
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = WADDR_W - IDX_W - WSEL_W;
  localparam int WAY_W   = $clog2(WAYS);

  logic [1:0]                 rst_sync_q;
  logic                       rst_core_n;
  logic [IDX_W-1:0]           set_idx;
  logic [TAG_W-1:0]           req_tag;
  logic [WAYS-1:0]            way_hit, way_valid, way_dirty;
  logic [WAYS-1:0][TAG_W-1:0] way_tag;
  logic [WAY_W-1:0]           lru_way;
  logic [WAYS-1:0][DATA_W-1:0] way_data;
  logic                       tag_fill, tag_dirty, lru_touch, dat_we;
  logic [WAY_W-1:0]           tag_fill_way, tag_dirty_way, lru_touch_way, dat_way;
  logic [WSEL_W-1:0]          dat_word, dat_rd_word;
  logic [DATA_W-1:0]          dat_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  cache_ctrl #(
    .WADDR_W(WADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .IDX_W(IDX_W),
    .WSEL_W(WSEL_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_core_n),
    .cfg_write_back(cfg_write_back), .cfg_write_alloc(cfg_write_alloc),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .set_idx(set_idx), .req_tag(req_tag),
    .way_hit(way_hit), .way_valid(way_valid), .way_dirty(way_dirty),
    .way_tag(way_tag), .lru_way(lru_way), .way_data(way_data),
    .tag_fill(tag_fill), .tag_fill_way(tag_fill_way),
    .tag_dirty(tag_dirty), .tag_dirty_way(tag_dirty_way),
    .lru_touch(lru_touch), .lru_touch_way(lru_touch_way),
    .dat_we(dat_we), .dat_way(dat_way), .dat_word(dat_word),
    .dat_wdata(dat_wdata), .dat_rd_word(dat_rd_word)
  );

  cache_tag_store #(
    .WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_core_n), .set_idx(set_idx), .cmp_tag(req_tag),
    .way_hit(way_hit), .way_valid(way_valid), .way_dirty(way_dirty),
    .way_tag(way_tag), .lru_way(lru_way),
    .fill_en(tag_fill), .fill_way(tag_fill_way),
    .dirty_en(tag_dirty), .dirty_way(tag_dirty_way),
    .touch_en(lru_touch), .touch_way(lru_touch_way)
  );

  cache_data_store #(
    .WAYS(WAYS), .SETS(SETS), .WPL(WPL), .IDX_W(IDX_W),
    .WSEL_W(WSEL_W), .DATA_W(DATA_W), .WAY_W(WAY_W)
  ) u_data (
    .clk(clk), .set_idx(set_idx), .rd_word(dat_rd_word),
    .wr_en(dat_we), .wr_way(dat_way), .wr_word(dat_word), .wr_data(dat_wdata),
    .rd_data(way_data)
  );
endmodule

// File: rtl/cache_checks.sv
module cache_checks #(
  parameter int WADDR_W = 14,
  parameter int DATA_W  = 32,
  parameter int WAYS    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_req,
  input logic               cpu_ready,
  input logic               cpu_done,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_ready,
  input logic [WADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0]  mem_wdata,
  input logic [WAYS-1:0]    way_hit,
  input logic               fill_done
);
  AST_HIT_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit)); // R2

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req); // R10

  AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready) |=> !cpu_ready); // R10

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> cpu_ready); // R3

  AST_FILL_ON_READ_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> (mem_req && !mem_we && mem_ready)); // R4
endmodule

bind set_assoc_cache cache_checks #(
  .WADDR_W(WADDR_W), .DATA_W(DATA_W), .WAYS(WAYS)
) u_checks (
  .clk(clk), .rst_n(rst_core_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .cpu_done(cpu_done), .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .way_hit(way_hit), .fill_done(tag_fill)
);

// File: tb/set_assoc_cache_test.sv
module set_assoc_cache_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_write_back, cfg_write_alloc;
  logic        cpu_req, cpu_we;
  logic [13:0] cpu_addr;
  logic [31:0] cpu_wdata;
  logic        cpu_ready, cpu_done;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [13:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ready;
  logic [31:0] mem_rdata;

  int n_total = 0;
  int n_bad   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  set_assoc_cache uut (
    .clk(clk), .rst_n(rst_n), .cfg_write_back(cfg_write_back), .cfg_write_alloc(cfg_write_alloc),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  // Behavioural model: memory, processor-visible contents, per-set recency lists.
  logic [31:0] mem_m  [int unsigned];
  logic [31:0] gold_m [int unsigned];
  int unsigned rec_q  [16][$];   // front = most recently used tag
  bit          dirty_m [int unsigned];

  bit          log_we   [$];
  logic [13:0] log_addr [$];
  logic [31:0] log_data [$];
  bit          exp_we   [$];
  logic [13:0] exp_addr [$];
  logic [31:0] exp_data [$];

  function automatic logic [31:0] seed_val(input logic [13:0] a);
    return 32'hC0DE_0000 ^ ({18'd0, a} * 32'h0000_9E37);
  endfunction

  function automatic logic [31:0] mem_rd(input logic [13:0] a);
    return mem_m.exists(a) ? mem_m[a] : seed_val(a);
  endfunction

  function automatic logic [31:0] gold_rd(input logic [13:0] a);
    return gold_m.exists(a) ? gold_m[a] : seed_val(a);
  endfunction

  function automatic logic [13:0] mk(input int t, input int s, input int w);
    return {8'(t), 4'(s), 2'(w)};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  // Memory responder: each beat is granted two cycles after it appears.
  initial begin
    int wait_cnt = 0;
    mem_ready = 1'b0;
    mem_rdata = '0;
    forever begin
      @(posedge clk);
      #2;
      if (mem_ready) begin
        mem_ready = 1'b0;
        wait_cnt = 0;
      end else if (mem_req) begin
        if (wait_cnt == 2) begin
          wait_cnt = 0;
          mem_ready = 1'b1;
          if (mem_we) begin
            mem_m[mem_addr] = mem_wdata;
            log_we.push_back(1'b1); log_addr.push_back(mem_addr); log_data.push_back(mem_wdata);
          end else begin
            mem_rdata = mem_rd(mem_addr);
            log_we.push_back(1'b0); log_addr.push_back(mem_addr); log_data.push_back(mem_rdata);
          end
        end else begin
          wait_cnt++;
        end
      end else begin
        wait_cnt = 0;
      end
    end
  end

  // Cycle monitor: an idle block never talks to memory (R10).
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && cpu_ready === 1'b1)
        chk(mem_req == 1'b0, "R10", "mem_req while idle", {31'd0, mem_req}, 32'd0);
    end
  end

  task automatic push_exp(input bit we, input logic [13:0] a, input logic [31:0] d);
    exp_we.push_back(we); exp_addr.push_back(a); exp_data.push_back(d);
  endtask

  task automatic model_fill(input int s, input int t);
    if (rec_q[s].size() == 2) begin
      int unsigned v = rec_q[s][1];
      int unsigned key = unsigned'(s * 256) + v;
      if (dirty_m.exists(key)) begin
        for (int b = 0; b < 4; b++) push_exp(1'b1, mk(int'(v), s, b), gold_rd(mk(int'(v), s, b)));
        dirty_m.delete(key);
      end
      void'(rec_q[s].pop_back());
    end
    for (int b = 0; b < 4; b++) push_exp(1'b0, mk(t, s, b), gold_rd(mk(t, s, b)));
    rec_q[s].push_front(unsigned'(t));
    dirty_m.delete(unsigned'(s * 256 + t));
  endtask

  task automatic do_op(input bit we, input logic [13:0] a, input logic [31:0] d,
                       input bit wb, input bit alloc, input string rq);
    int s = int'(a[5:2]);
    int t = int'(a[13:6]);
    int found = -1;
    bit fast;
    logic [31:0] exp_rd = '0;
    int lat;
    exp_we.delete(); exp_addr.delete(); exp_data.delete();
    for (int i = 0; i < rec_q[s].size(); i++) if (rec_q[s][i] == unsigned'(t)) found = i;
    if (!we) begin
      fast = (found >= 0);
      if (found < 0) model_fill(s, t);
      else begin rec_q[s].delete(found); rec_q[s].push_front(unsigned'(t)); end
      exp_rd = gold_rd(a);
    end else if (found < 0 && !alloc) begin
      fast = 1'b0;
      push_exp(1'b1, a, d);
      gold_m[a] = d;
    end else begin
      if (found < 0) model_fill(s, t);
      else begin rec_q[s].delete(found); rec_q[s].push_front(unsigned'(t)); end
      gold_m[a] = d;
      if (wb) begin
        dirty_m[unsigned'(s * 256 + t)] = 1'b1;
        fast = (found >= 0);
      end else begin
        push_exp(1'b1, a, d);
        fast = 1'b0;
      end
    end
    log_we.delete(); log_addr.delete(); log_data.delete();
    @(negedge clk);
    cfg_write_back = wb; cfg_write_alloc = alloc;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    lat = 1;
    while (cpu_done !== 1'b1 && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    chk(lat < 400, rq, "completion", 32'(lat), 32'd0);
    if (!we) chk(cpu_rdata === exp_rd, rq, "read data", cpu_rdata, exp_rd);
    if (fast) chk(lat == 1, rq, "hit latency", 32'(lat), 32'd1);
    chk(log_we.size() == exp_we.size(), rq, "beat count", 32'(log_we.size()), 32'(exp_we.size()));
    for (int i = 0; i < exp_we.size() && i < log_we.size(); i++) begin
      chk(log_we[i] == exp_we[i] && log_addr[i] == exp_addr[i] && log_data[i] == exp_data[i],
          rq, $sformatf("beat %0d dir=%0d addr", i, log_we[i]),
          {18'd0, log_addr[i]}, {18'd0, exp_addr[i]});
    end
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_write_back = 1'b1; cfg_write_alloc = 1'b1;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cpu_ready === 1'b1, "R11", "ready after reset", {31'd0, cpu_ready}, 32'd1);
    chk(mem_req === 1'b0, "R11", "mem idle after reset", {31'd0, mem_req}, 32'd0);

    // write-back, write-allocate
    do_op(0, mk(1, 0, 1), 0, 1, 1, "R11");
    do_op(0, mk(1, 0, 2), 0, 1, 1, "R3");
    do_op(0, mk(1, 0, 3), 0, 1, 1, "R1");
    do_op(0, mk(2, 0, 1), 0, 1, 1, "R4");
    do_op(0, mk(1, 1, 0), 0, 1, 1, "R2");
    do_op(0, mk(1, 0, 0), 0, 1, 1, "R5");
    do_op(0, mk(3, 0, 0), 0, 1, 1, "R5");
    do_op(0, mk(1, 0, 3), 0, 1, 1, "R5");
    do_op(1, mk(1, 0, 2), 32'hDEAD_0001, 1, 1, "R7");
    do_op(0, mk(1, 0, 2), 0, 1, 1, "R7");
    do_op(0, mk(4, 0, 0), 0, 1, 1, "R5");
    do_op(0, mk(5, 0, 0), 0, 1, 1, "R7");
    do_op(0, mk(1, 0, 2), 0, 1, 1, "R7");
    // write-through
    do_op(1, mk(1, 0, 1), 32'h1234_5678, 0, 1, "R6");
    do_op(0, mk(1, 0, 1), 0, 0, 1, "R6");
    do_op(1, mk(6, 2, 3), 32'hA0A0_0606, 0, 1, "R8");
    do_op(0, mk(6, 2, 3), 0, 0, 1, "R8");
    // no-write-allocate
    do_op(1, mk(7, 3, 0), 32'h0707_0707, 0, 0, "R9");
    do_op(0, mk(7, 3, 0), 0, 0, 0, "R9");
    do_op(1, mk(8, 2, 0), 32'h0808_0808, 1, 0, "R9");
    do_op(0, mk(9, 2, 0), 0, 1, 0, "R9");
    do_op(1, mk(12, 2, 1), 32'h0C0C_0C0C, 1, 0, "R9");
    do_op(0, mk(10, 2, 0), 0, 1, 0, "R9");
    do_op(0, mk(8, 2, 0), 0, 1, 0, "R9");
    // write-back with allocate on a miss
    do_op(1, mk(11, 4, 1), 32'hBEEF_0B0B, 1, 1, "R8");
    do_op(0, mk(11, 4, 1), 0, 1, 1, "R8");

    // mixed traffic over a few sets and tags, policies changing per request
    for (int i = 0; i < 300; i++) begin
      logic [13:0] a = mk(int'($urandom % 6), int'($urandom % 4), int'($urandom % 4));
      do_op(1'($urandom), a, $urandom, 1'($urandom), 1'($urandom), "R2");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_total++;
      n_bad++;
      $display("FAIL R10 watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end
endmodule